// File: doc/BRIEF.md
# Unrolled Bitsliced SP-Network Encryptor

This block encrypts one 64-bit block per clock with every round of the cipher and every step of its key schedule laid out as combinational logic. The data is held as four 16-bit rows. Each of the 25 rounds does three things in order. It XORs in a 64-bit subkey. It passes each vertical 4-bit column through a single 4-bit substitution box. It then rotates each row left by a fixed amount that differs from row to row. One more subkey XOR after the last round gives the ciphertext.

The key can be 80 or 128 bits wide, chosen by a parameter. The key schedule runs beside the data path and produces all 26 subkeys at the same time. Each step substitutes only the lowest column of the key state, rotates and mixes the key rows, and XORs in a constant taken from a 5-bit shift-register sequence. The result goes into one output register. A new plaintext and key can be applied on every cycle, and the matching ciphertext appears one clock later.

Top module: `spn_unrolled_enc`

## Requirements
- R1: The block is 64 bits wide. Bit j of state row r (r in 0..3, j in 0..15) is bit 16*r+j of the plaintext bus, of every internal state and of the ciphertext bus.
- R2: The substitution maps 0..F to 6,5,C,A,1,E,7,9,B,0,3,D,8,F,4,2. For column j, the input nibble has bit k (k = 0 for the least significant bit) equal to row k bit j, and output bit k goes back to row k bit j.
- R3: After substitution, rows 0, 1, 2 and 3 are rotated left by 0, 1, 12 and 13 positions. Left means toward higher bit indices.
- R4: Each of the 25 rounds applies, in order, the XOR with subkey i (i = 0..24), the column substitution and the row rotations. The ciphertext is the round-25 state XORed with subkey 25.
- R5: Subkey i holds, in its row r, the low 16 bits of row r of key state i, for r = 0..3. Key state 0 is the key input, so subkey 0 is taken directly from the key bus.
- R6: To go from key state i to key state i+1, the step first substitutes only column 0 of the key state. That column is bit 0 of key rows 0..3, with row 0 as the nibble's least significant bit. All other key bits pass unchanged to the row update.
- R7: With KEY_W = 80, the key has five 16-bit rows (row r = key bits 16*r+15..16*r). After substitution the rows update as: new row0 = (row0 rotl 8) XOR row1, new row1 = row2, new row2 = row3, new row3 = (row3 rotl 12) XOR row4, new row4 = row0.
- R8: With KEY_W = 128, the key has four 32-bit rows (row r = key bits 32*r+31..32*r). After substitution the rows update as: new row0 = (row0 rotl 8) XOR row1, new row1 = row2, new row2 = (row2 rotl 16) XOR row3, new row3 = row0.
- R9: The round constant for step i is state i of a 5-bit sequence that starts at 5'b00001 and advances as next = {s[3:0], s[4]^s[2]}. It is XORed into bits 4..0 of the new key row 0.
- R10: The ciphertext output is registered. It shows the encryption of the plaintext and key present at the previous rising clock edge, and it does not change while those inputs are held.
- R11: A synchronous active-high reset forces the ciphertext register to zero at the next rising edge.
- R12: Under one key, two different plaintexts always produce different ciphertexts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| plaintext | input | 64 | Block to encrypt |
| key | input | KEY_W | Cipher key (80 or 128 bits) |
| ciphertext | output | 64 | Registered encrypted block |

## Verification
Three kinds of patterns are used. All-zero and all-ones inputs show whether the round constants and the fixed substitution points are placed correctly, because without them these symmetric inputs would give symmetric results. Single-bit plaintexts and keys, including the top key bit in both widths, follow one set bit through the rotations and the key-row shuffle, which catches a wrong offset or a wrong row order. Random plaintext and key pairs are run through both key widths. Pairs that differ in one plaintext bit under a held key check that distinct blocks never collide. Held inputs and a reset in the middle of traffic check the one-cycle latency and the clearing of the output register.

// File: rtl/spn_pkg.sv
package spn_pkg;
  localparam int BLK_W    = 64;
  localparam int ROW_W    = 16;
  localparam int N_ROWS   = 4;
  localparam int N_ROUNDS = 25;
  localparam int RC_W     = 5;

  typedef logic [ROW_W-1:0] row_t;

  function automatic logic [3:0] sbox4(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'h6;  4'h1: y = 4'h5;  4'h2: y = 4'hC;  4'h3: y = 4'hA;
      4'h4: y = 4'h1;  4'h5: y = 4'hE;  4'h6: y = 4'h7;  4'h7: y = 4'h9;
      4'h8: y = 4'hB;  4'h9: y = 4'h0;  4'hA: y = 4'h3;  4'hB: y = 4'hD;
      4'hC: y = 4'h8;  4'hD: y = 4'hF;  4'hE: y = 4'h4;  default: y = 4'h2;
    endcase
    return y;
  endfunction

  // left rotation amount of each data row
  function automatic int unsigned row_rot(input int r);
    case (r)
      0: return 0;
      1: return 1;
      2: return 12;
      default: return 13;
    endcase
  endfunction

  function automatic row_t rotl_row(input row_t v, input int unsigned n);
    return (v << n) | (v >> (ROW_W - n));
  endfunction

  // state i of the constant sequence
  function automatic logic [RC_W-1:0] rc_at(input int i);
    logic [RC_W-1:0] s;
    s = 5'b00001;
    for (int k = 0; k < i; k++) s = {s[3:0], s[4] ^ s[2]};
    return s;
  endfunction
endpackage

// File: rtl/spn_round.sv
module spn_round import spn_pkg::*; (
  input  logic [BLK_W-1:0] din,
  input  logic [BLK_W-1:0] rkey,
  output logic [BLK_W-1:0] dout
);
  logic [BLK_W-1:0] mixed;
  logic [BLK_W-1:0] subbed;

  assign mixed = din ^ rkey;

  for (genvar c = 0; c < ROW_W; c++) begin : g_col
    logic [3:0] nib_in;
    logic [3:0] nib_out;
    for (genvar r = 0; r < N_ROWS; r++) begin : g_gather
      assign nib_in[r] = mixed[r*ROW_W + c];
    end
    assign nib_out = sbox4(nib_in);
    for (genvar r = 0; r < N_ROWS; r++) begin : g_scatter
      assign subbed[r*ROW_W + c] = nib_out[r];
    end
  end

  for (genvar r = 0; r < N_ROWS; r++) begin : g_rot
    assign dout[r*ROW_W +: ROW_W] = rotl_row(subbed[r*ROW_W +: ROW_W], row_rot(r));
  end
endmodule

// File: rtl/spn_key_step.sv
module spn_key_step import spn_pkg::*; #(
  parameter int              KEY_W = 80,
  parameter logic [RC_W-1:0] RC    = 5'b00001
) (
  input  logic [KEY_W-1:0] kin,
  output logic [KEY_W-1:0] kout
);
  localparam int KR_W = (KEY_W == 128) ? 32 : 16;
  localparam int KR_N = KEY_W / KR_W;

  function automatic logic [KR_W-1:0] rotk(input logic [KR_W-1:0] v, input int unsigned n);
    return (v << n) | (v >> (KR_W - n));
  endfunction

  logic [3:0]      c0_in;
  logic [3:0]      c0_out;
  logic [KEY_W-1:0] ks;
  logic [KR_W-1:0] row  [KR_N];
  logic [KR_W-1:0] nrow [KR_N];

  for (genvar r = 0; r < 4; r++) begin : g_c0
    assign c0_in[r] = kin[r*KR_W];
  end
  assign c0_out = sbox4(c0_in);

  always_comb begin
    ks = kin;
    for (int r = 0; r < 4; r++) ks[r*KR_W] = c0_out[r];
  end

  for (genvar r = 0; r < KR_N; r++) begin : g_rows
    assign row[r] = ks[r*KR_W +: KR_W];
  end

  if (KR_N == 5) begin : g_narrow
    assign nrow[0] = rotk(row[0], 8) ^ row[1];
    assign nrow[1] = row[2];
    assign nrow[2] = row[3];
    assign nrow[3] = rotk(row[3], 12) ^ row[4];
    assign nrow[4] = row[0];
  end else begin : g_wide
    assign nrow[0] = rotk(row[0], 8) ^ row[1];
    assign nrow[1] = row[2];
    assign nrow[2] = rotk(row[2], 16) ^ row[3];
    assign nrow[3] = row[0];
  end

  assign kout[0 +: KR_W] = nrow[0] ^ KR_W'(RC);
  for (genvar r = 1; r < KR_N; r++) begin : g_out
    assign kout[r*KR_W +: KR_W] = nrow[r];
  end
endmodule

// File: rtl/spn_key_sched.sv
module spn_key_sched import spn_pkg::*; #(
  parameter int KEY_W = 80
) (
  input  logic [KEY_W-1:0]              key,
  output logic [N_ROUNDS:0][BLK_W-1:0] subkeys
);
  localparam int KR_W = (KEY_W == 128) ? 32 : 16;

  logic [KEY_W-1:0] kst [N_ROUNDS+1];

  assign kst[0] = key;

  for (genvar i = 0; i < N_ROUNDS; i++) begin : g_step
    spn_key_step #(.KEY_W(KEY_W), .RC(rc_at(i))) u_step (
      .kin (kst[i]),
      .kout(kst[i+1])
    );
  end

  for (genvar i = 0; i <= N_ROUNDS; i++) begin : g_sk
    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      assign subkeys[i][r*ROW_W +: ROW_W] = kst[i][r*KR_W +: ROW_W];
    end
  end
endmodule

// File: rtl/spn_unrolled_enc.sv
module spn_unrolled_enc import spn_pkg::*; #(
  parameter int KEY_W = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BLK_W-1:0] plaintext,
  input  logic [KEY_W-1:0] key,
  output logic [BLK_W-1:0] ciphertext
);
  logic [N_ROUNDS:0][BLK_W-1:0] subkeys;
  logic [N_ROUNDS:0][BLK_W-1:0] st;
  logic [BLK_W-1:0]             ct_d;

  spn_key_sched #(.KEY_W(KEY_W)) u_ks (
    .key    (key),
    .subkeys(subkeys)
  );

  assign st[0] = plaintext;

  for (genvar i = 0; i < N_ROUNDS; i++) begin : g_rnd
    spn_round u_rnd (
      .din (st[i]),
      .rkey(subkeys[i]),
      .dout(st[i+1])
    );
  end

  assign ct_d = st[N_ROUNDS] ^ subkeys[N_ROUNDS];

  always_ff @(posedge clk) begin
    if (rst) ciphertext <= '0;
    else     ciphertext <= ct_d;
  end
endmodule

// File: rtl/spn_unrolled_enc_chk.sv
module spn_unrolled_enc_chk #(
  parameter int KEY_W = 80
) (
  input logic             clk,
  input logic             rst,
  input logic [63:0]      plaintext,
  input logic [KEY_W-1:0] key,
  input logic [63:0]      ciphertext,
  input logic [63:0]      subkey0
);
  localparam int KR_W = (KEY_W == 128) ? 32 : 16;

  logic [63:0] sk0_exp;
  for (genvar r = 0; r < 4; r++) begin : g_exp
    assign sk0_exp[r*16 +: 16] = key[r*KR_W +: 16];
  end

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> ciphertext == '0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(plaintext) && $stable(key)) |=> $stable(ciphertext));

  assert_distinct_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(key) && !$stable(plaintext)) |=> !$stable(ciphertext));

  assert_first_subkey_R5: assert property (@(posedge clk) disable iff (rst)
    subkey0 == sk0_exp);
endmodule

bind spn_unrolled_enc spn_unrolled_enc_chk #(.KEY_W(KEY_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .plaintext (plaintext),
  .key       (key),
  .ciphertext(ciphertext),
  .subkey0   (subkeys[0])
);

// File: tb/spn_unrolled_enc_test.sv
module spn_unrolled_enc_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [63:0]  pt = '0;
  logic [79:0]  key80 = '0;
  logic [127:0] key128 = '0;
  logic [63:0]  ct80;
  logic [63:0]  ct128;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spn_unrolled_enc #(.KEY_W(80)) uut (
    .clk(clk), .rst(rst), .plaintext(pt), .key(key80), .ciphertext(ct80));

  spn_unrolled_enc #(.KEY_W(128)) uut_wide (
    .clk(clk), .rst(rst), .plaintext(pt), .key(key128), .ciphertext(ct128));

  function automatic logic [3:0] m_sbox(input logic [3:0] x);
    logic [63:0] tbl;
    tbl = 64'h24F8_D30B_97E1_AC56;
    return tbl[4*x +: 4];
  endfunction

  function automatic logic [31:0] m_rotl(input logic [31:0] v, input int n, input int w);
    logic [31:0] o;
    o = '0;
    for (int k = 0; k < w; k++) o[(k + n) % w] = v[k];
    return o;
  endfunction

  function automatic logic [63:0] m_enc(input logic [63:0] p, input logic [127:0] k, input bit wide);
    logic [63:0] s, t, sk;
    logic [31:0] kr [5];
    logic [31:0] nk [5];
    logic [4:0]  lf;
    logic [3:0]  nb, ob;
    int w, nr;
    w  = wide ? 32 : 16;
    nr = wide ? 4 : 5;
    for (int r = 0; r < 5; r++) kr[r] = '0;
    for (int r = 0; r < nr; r++)
      for (int b = 0; b < w; b++) kr[r][b] = k[r*w + b];
    lf = 5'b00001;
    s = p;
    for (int rnd = 0; rnd <= 25; rnd++) begin
      sk = {kr[3][15:0], kr[2][15:0], kr[1][15:0], kr[0][15:0]};
      s = s ^ sk;
      if (rnd == 25) break;
      for (int c = 0; c < 16; c++) begin
        nb = {s[48+c], s[32+c], s[16+c], s[c]};
        ob = m_sbox(nb);
        for (int r = 0; r < 4; r++) s[16*r + c] = ob[r];
      end
      t = s;
      for (int r = 0; r < 4; r++) begin
        int a;
        a = (r == 0) ? 0 : (r == 1) ? 1 : (r == 2) ? 12 : 13;
        s[16*r +: 16] = m_rotl({16'h0, t[16*r +: 16]}, a, 16);
      end
      ob = m_sbox({kr[3][0], kr[2][0], kr[1][0], kr[0][0]});
      for (int r = 0; r < 4; r++) kr[r][0] = ob[r];
      nk[4] = '0;
      if (!wide) begin
        nk[0] = m_rotl(kr[0], 8, 16) ^ kr[1];
        nk[1] = kr[2];
        nk[2] = kr[3];
        nk[3] = m_rotl(kr[3], 12, 16) ^ kr[4];
        nk[4] = kr[0];
      end else begin
        nk[0] = m_rotl(kr[0], 8, 32) ^ kr[1];
        nk[1] = kr[2];
        nk[2] = m_rotl(kr[2], 16, 32) ^ kr[3];
        nk[3] = kr[0];
      end
      nk[0][4:0] = nk[0][4:0] ^ lf;
      lf = {lf[3:0], lf[4] ^ lf[2]};
      for (int r = 0; r < 5; r++) kr[r] = nk[r];
    end
    return s;
  endfunction

  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // apply at a falling edge, result is registered at the next rising edge
  task automatic run_vec(input logic [63:0] p, input logic [127:0] k, input string what);
    @(negedge clk);
    pt = p; key80 = k[79:0]; key128 = k;
    @(negedge clk);
    chk(ct80,  m_enc(p, {48'h0, k[79:0]}, 1'b0), {what, " k80"});
    chk(ct128, m_enc(p, k, 1'b1), {what, " k128"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held80, held128, a80, a128;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(ct80, 64'h0, "R11 reset k80");
    chk(ct128, 64'h0, "R11 reset k128");
    rst = 1'b0;

    // directed corners: R1 R2 R3 R4 R5 R6 R7 R8 R9
    run_vec(64'h0, 128'h0, "R4 R9 zero block zero key");
    run_vec({64{1'b1}}, {128{1'b1}}, "R2 R4 all ones");
    run_vec(64'h0000_0000_0000_0001, 128'h0, "R1 R3 plaintext bit0");
    run_vec(64'h8000_0000_0000_0000, 128'h0, "R1 R3 plaintext bit63");
    run_vec(64'h0, 128'h0000_0000_0000_0000_0000_0000_0000_0001, "R5 R6 key bit0");
    run_vec(64'h0, {48'h0, 80'h8000_0000_0000_0000_0000}, "R7 key bit79");
    run_vec(64'h0, 128'h8000_0000_0000_0000_0000_0000_0000_0000, "R8 key bit127");
    run_vec(64'h0123_4567_89AB_CDEF, 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0, "R4 R7 R8 mixed");

    // R10: held inputs keep the output; a change shows one edge later
    held80 = ct80; held128 = ct128;
    repeat (3) @(negedge clk);
    chk(ct80, held80, "R10 hold k80");
    chk(ct128, held128, "R10 hold k128");
    pt = 64'hDEAD_BEEF_0000_FFFF;
    #2;
    chk(ct80, held80, "R10 before edge k80");
    @(negedge clk);
    chk(ct80, m_enc(pt, {48'h0, key80}, 1'b0), "R10 after edge k80");

    // R12: one-bit plaintext difference under a fixed key
    run_vec(64'h5555_AAAA_3333_CCCC, 128'h1234_5678_9ABC_DEF0_1111_2222_3333_4444, "R12 base");
    a80 = ct80; a128 = ct128;
    run_vec(64'h5555_AAAA_3333_CCCD, 128'h1234_5678_9ABC_DEF0_1111_2222_3333_4444, "R12 flipped");
    n_chk++;
    if (a80 == ct80 || a128 == ct128) begin
      n_bad++;
      $display("FAIL R12 collision: got %h/%h expected differ from %h/%h", ct80, ct128, a80, a128);
    end

    // R11: reset in the middle of traffic
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(ct80, 64'h0, "R11 mid reset k80");
    chk(ct128, 64'h0, "R11 mid reset k128");
    rst = 1'b0;

    // random traffic: R1..R9 against the bench model
    for (int i = 0; i < 200; i++) begin
      run_vec({$urandom(), $urandom()}, {$urandom(), $urandom(), $urandom(), $urandom()},
              "R4 R6 R7 R8 R9 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule